// File: doc/BRIEF.md
# Branch Trace Message Buffer

This block records a live execution trace from a processor that retires through two pipes at once. It samples three retirement strobes every clock: an instruction retired in the first pipe, one retired in the second pipe, and a taken branch. It does not store one entry per instruction. An incident counter totals the plain retirements between taken branches. Each taken branch then produces one 48-bit message that holds the count and the branch target.

Messages go into a 16-entry on-chip queue. A debug agent drains the queue over a valid/ready port while the core keeps running. The agent may also drain it later, from a halted state.

Two policies cover a full queue:
- **Wrap policy.** The oldest entry is discarded, so the queue always holds the most recent history. A breakpoint strobe freezes capture, which keeps the lead-up to the stop intact.
- **Halt policy.** Nothing may be lost. The message that finds the queue full is parked, and the block asks the core to halt until the agent has removed an entry.

Top module: `trc_buffer`

## Requirements
- R1: After reset the read port shows no data (`rd_valid_o`=0), `halt_req_o` is low, capture is disabled and the incident count is zero.
- R2: Each cycle, capture adds to the incident count the number of non-branch retirements: `pipe_u_i`+`pipe_v_i`, less one when `br_taken_i` is high (never below zero).
- R3: A cycle with `br_taken_i` high during capture writes the message {count[47:32], target[31:0]}. The count field is the value held before that cycle, the target field is `br_target_i`, and the counter restarts at that cycle's non-branch retirements.
- R4: When adding a cycle's retirements would take the count past 16'hFFFF, the block writes a message whose count field is the pre-cycle count and whose target is 32'hFFFFFFFF, and the counter restarts at that cycle's retirements.
- R5: Messages leave the read port in the order they were written. A transfer occurs in any cycle with `rd_valid_o` and `rd_ready_i` both high, and entries can be drained while capture continues.
- R6: With `rd_valid_o` low, `rd_ready_i` has no effect.
- R7: In wrap policy (`cfg_mode_i`=0), a message that arrives at a full 16-entry queue with no transfer in that cycle replaces the oldest entry.
- R8: In wrap policy, a cycle with `brk_i` high suppresses capture in that cycle and in every later cycle, until capture is enabled afresh.
- R9: In halt policy (`cfg_mode_i`=1), a message that arrives at a full queue with no transfer is held and `halt_req_o` rises in the next cycle. It stays high until a transfer, which also appends the held message; `halt_req_o` is low the cycle after.
- R10: A `cfg_we_i` write loads both enable and mode only while capture is disabled. While capture is enabled, only a write with `cfg_en_i`=0 has any effect, and it clears enable alone. Enabling clears the incident count and the breakpoint freeze.
- R11: While capture is disabled, no message is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_en_i | input | 1 | Capture enable value to write |
| cfg_mode_i | input | 1 | Full policy to write: 0 wrap, 1 halt |
| pipe_u_i | input | 1 | Instruction retired in first pipe |
| pipe_v_i | input | 1 | Instruction retired in second pipe |
| br_taken_i | input | 1 | Retiring instruction is a taken branch |
| br_target_i | input | 32 | Target address of the taken branch |
| brk_i | input | 1 | Breakpoint strobe |
| rd_ready_i | input | 1 | Debug agent accepts the head entry |
| rd_valid_o | output | 1 | Head entry present |
| rd_data_o | output | 48 | Head entry {count, target} |
| halt_req_o | output | 1 | Request to halt the core |

## Verification
Retirement patterns use one pipe, the other pipe, both pipes, and branches that retire alone or beside a plain instruction. Together they separate a correct per-cycle sum from off-by-one handling of the branch slot. A run of about 33k dual retirements pushes the counter to its limit, which tells the overflow message apart from silent wrap-around. Writing 20 messages without reading shows whether the oldest entries were dropped or the newest. A breakpoint landing on a branch cycle, and a 17th message under the halt policy, pin down the exact cycle in which capture stops and in which the halt request is raised and cleared.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic {
    MODE_WRAP  = 1'b0,
    MODE_PROBE = 1'b1
  } trc_mode_e;
endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cfg_we_i,
  input  logic      cfg_en_i,
  input  logic      cfg_mode_i,
  input  logic      brk_i,
  output logic      en_o,
  output trc_mode_e mode_o,
  output logic      start_o,
  output logic      cap_o
);
  logic      en_q, frozen_q;
  trc_mode_e mode_q;
  logic      brk_hit;

  assign start_o = cfg_we_i & ~en_q & cfg_en_i;
  assign brk_hit = en_q & ~frozen_q & (mode_q == MODE_WRAP) & brk_i;
  assign cap_o   = en_q & ~frozen_q & ~brk_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      mode_q   <= MODE_WRAP;
      frozen_q <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        if (!en_q) begin
          en_q   <= cfg_en_i;
          mode_q <= trc_mode_e'(cfg_mode_i);
        end else if (!cfg_en_i) begin
          en_q <= 1'b0;
        end
      end
      if (start_o)      frozen_q <= 1'b0;
      else if (brk_hit) frozen_q <= 1'b1;
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/trc_msg_gen.sv
module trc_msg_gen #(
  parameter int CNT_W = 16,
  parameter int TGT_W = 32,
  localparam int MSG_W = CNT_W + TGT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             clr_i,
  input  logic             pipe_u_i,
  input  logic             pipe_v_i,
  input  logic             br_taken_i,
  input  logic [TGT_W-1:0] br_target_i,
  output logic             emit_o,
  output logic [MSG_W-1:0] msg_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       n_ret, n_plain;
  logic [CNT_W:0]   sum;
  logic             ovf;

  assign n_ret   = 2'(pipe_u_i) + 2'(pipe_v_i);
  // the taken branch occupies one retirement slot
  assign n_plain = br_taken_i ? ((n_ret != 2'd0) ? n_ret - 2'd1 : 2'd0) : n_ret;
  assign sum     = {1'b0, cnt_q} + (CNT_W+1)'(n_plain);
  assign ovf     = sum[CNT_W];
  assign emit_o  = cap_i & (br_taken_i | ovf);
  assign msg_o   = {cnt_q, br_taken_i ? br_target_i : {TGT_W{1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (cap_i)  cnt_q <= emit_o ? CNT_W'(n_plain) : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/trc_fifo.sv
module trc_fifo #(
  parameter int W     = 48,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          wrap_i,
  input  logic [W-1:0]  data_i,
  output logic [W-1:0]  data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;
  logic          do_wr, do_rd, drop_old;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o  = (count_q == '0);
  assign full_o   = (count_q == CW'(DEPTH));
  assign do_rd    = pop_i & ~empty_o;
  assign drop_old = push_i & full_o & ~do_rd & wrap_i;
  assign do_wr    = push_i & (~full_o | do_rd | wrap_i);

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[tail_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_wr)            tail_q <= nxt(tail_q);
      if (do_rd | drop_old) head_q <= nxt(head_q);
      if (do_wr & ~(do_rd | drop_old))      count_q <= count_q + 1'b1;
      else if (~do_wr & do_rd)              count_q <= count_q - 1'b1;
    end
  end

  assign data_o  = mem[head_q];
  assign count_o = count_q;
endmodule

// File: rtl/trc_buffer.sv
module trc_buffer
  import trc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TGT_W = 32,
  parameter int DEPTH = 16,
  localparam int MSG_W = CNT_W + TGT_W,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic             cfg_mode_i,
  input  logic             pipe_u_i,
  input  logic             pipe_v_i,
  input  logic             br_taken_i,
  input  logic [TGT_W-1:0] br_target_i,
  input  logic             brk_i,
  input  logic             rd_ready_i,
  output logic             rd_valid_o,
  output logic [MSG_W-1:0] rd_data_o,
  output logic             halt_req_o
);
  logic             en, start, cap, emit;
  trc_mode_e        mode;
  logic [MSG_W-1:0] msg, pend_q, fifo_din;
  logic             pend_v_q, fifo_push, fifo_empty, fifo_full, pop, stall;
  logic [CW-1:0]    fifo_count;

  trc_ctrl u_ctrl (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_en_i, .cfg_mode_i, .brk_i,
    .en_o(en), .mode_o(mode), .start_o(start), .cap_o(cap)
  );

  trc_msg_gen #(.CNT_W(CNT_W), .TGT_W(TGT_W)) u_gen (
    .clk_i, .rst_ni, .cap_i(cap), .clr_i(start),
    .pipe_u_i, .pipe_v_i, .br_taken_i, .br_target_i,
    .emit_o(emit), .msg_o(msg)
  );

  assign pop       = rd_valid_o & rd_ready_i;
  // halt policy: park the message that would not fit
  assign stall     = emit & ~pend_v_q & fifo_full & ~pop & (mode == MODE_PROBE);
  assign fifo_push = pend_v_q ? pop : (emit & ~stall);
  assign fifo_din  = pend_v_q ? pend_q : msg;

  trc_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(fifo_push), .pop_i(pop),
    .wrap_i(mode == MODE_WRAP), .data_i(fifo_din),
    .data_o(rd_data_o), .empty_o(fifo_empty), .full_o(fifo_full),
    .count_o(fifo_count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q <= 1'b0;
      pend_q   <= '0;
    end else if (stall) begin
      pend_v_q <= 1'b1;
      pend_q   <= msg;
    end else if (pend_v_q && pop) begin
      pend_v_q <= 1'b0;
    end
  end

  assign rd_valid_o = ~fifo_empty;
  assign halt_req_o = pend_v_q;
endmodule

module trc_buffer_chk
  import trc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int MSG_W = 48,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             rd_ready_i,
  input logic             rd_valid_o,
  input logic [MSG_W-1:0] rd_data_o,
  input logic             halt_req_o,
  input logic             en,
  input trc_mode_e        mode,
  input logic             fifo_push,
  input logic [CW-1:0]    fifo_count
);
  // R9
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o && !(rd_valid_o && rd_ready_i) |=> halt_req_o);
  // R9
  halt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_req_o) |-> $past(fifo_count) == CW'(DEPTH));
  // R5
  hold_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i && !fifo_push |=> rd_valid_o && $stable(rd_data_o));
  // R6
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o && !fifo_push |=> !rd_valid_o);
  // R10
  cfg_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && cfg_we_i |=> $stable(mode));
  // R7
  depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_count <= CW'(DEPTH));
endmodule

bind trc_buffer trc_buffer_chk #(.DEPTH(DEPTH), .MSG_W(MSG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .rd_ready_i(rd_ready_i),
  .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .halt_req_o(halt_req_o),
  .en(en), .mode(mode), .fifo_push(fifo_push), .fifo_count(fifo_count)
);

// File: tb/trc_buffer_bench.sv
module trc_buffer_bench;
  localparam int DEPTH = 16;
  localparam int MAXC  = 65535;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_en = 0, cfg_mode = 0;
  logic pu = 0, pv = 0, bt = 0, brk = 0, rdy = 0;
  logic [31:0] tgt = '0;
  logic        rd_valid, halt;
  logic [47:0] rd_data;

  int tests = 0, fails = 0;
  string cur = "R1";

  always #10 clk = ~clk;

  trc_buffer u_trc_buffer (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en),
    .cfg_mode_i(cfg_mode), .pipe_u_i(pu), .pipe_v_i(pv), .br_taken_i(bt),
    .br_target_i(tgt), .brk_i(brk), .rd_ready_i(rdy), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .halt_req_o(halt)
  );

  // reference model
  logic [47:0] q[$];
  int  m_cnt; bit m_en, m_mode, m_frz, m_pv; logic [47:0] m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_cnt = 0; m_en = 0; m_mode = 0; m_frz = 0; m_pv = 0; m_pend = '0;
    end else begin
      int n, nb, s; bit cap, emit, pop, start; logic [47:0] m;
      n = int'(pu) + int'(pv);
      nb = bt ? ((n > 0) ? n - 1 : 0) : n;
      cap = m_en && !m_frz && !(m_mode == 0 && brk);
      pop = (q.size() > 0) && rdy;
      emit = 0;
      if (cap) begin
        s = m_cnt + nb;
        if (bt || s > MAXC) begin
          emit = 1; m = {m_cnt[15:0], bt ? tgt : 32'hFFFF_FFFF}; m_cnt = nb;
        end else m_cnt = s;
      end
      if (m_pv) begin
        if (pop) begin void'(q.pop_front()); q.push_back(m_pend); m_pv = 0; end
      end else begin
        if (pop) void'(q.pop_front());
        if (emit) begin
          if (q.size() < DEPTH) q.push_back(m);
          else if (m_mode == 0) begin void'(q.pop_front()); q.push_back(m); end
          else begin m_pend = m; m_pv = 1; end
        end
      end
      if (m_en && !m_frz && m_mode == 0 && brk) m_frz = 1;
      start = cfg_we && !m_en && cfg_en;
      if (cfg_we) begin
        if (!m_en) begin m_en = cfg_en; m_mode = cfg_mode; end
        else if (!cfg_en) m_en = 0;
      end
      if (start) begin m_cnt = 0; m_frz = 0; end
    end
  end

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur, " valid"}, 48'(rd_valid), 48'(q.size() > 0));
      chk({cur, " halt"}, 48'(halt), 48'(m_pv));
      if (rd_valid && q.size() > 0) chk({cur, " data"}, rd_data, q[0]);
    end
  end

  task automatic step(bit u, bit v, bit b, logic [31:0] t, bit k = 0);
    pu = u; pv = v; bt = b; tgt = t; brk = k;
    @(negedge clk);
    pu = 0; pv = 0; bt = 0; tgt = '0; brk = 0;
  endtask

  task automatic cfg(bit e, bit md);
    cfg_we = 1; cfg_en = e; cfg_mode = md;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pop_exp(string req, logic [47:0] exp);
    chk({req, " head valid"}, 48'(rd_valid), 48'd1);
    chk({req, " head"}, rd_data, exp);
    rdy = 1; @(negedge clk); rdy = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 48'(rd_valid), 48'd0);
    chk("R1 halt", 48'(halt), 48'd0);
    // R11 disabled: branches write nothing
    cur = "R11";
    step(1, 1, 1, 32'hAAAA);
    chk("R11 nothing captured", 48'(rd_valid), 48'd0);

    // R2, R3 counting and message format
    cur = "R3";
    cfg(1, 0);
    step(1, 0, 0, 0); step(1, 1, 0, 0); step(0, 1, 0, 0);
    step(1, 1, 1, 32'h0000_1000);
    step(1, 0, 0, 0);
    step(1, 0, 1, 32'h0000_2000);
    pop_exp("R2", {16'd4, 32'h0000_1000});
    pop_exp("R3", {16'd2, 32'h0000_2000});

    // R6 reading an empty queue
    cur = "R6";
    rdy = 1; repeat (3) @(negedge clk); rdy = 0;
    chk("R6 still empty", 48'(rd_valid), 48'd0);
    step(0, 0, 1, 32'h0000_3000);
    pop_exp("R6", {16'd0, 32'h0000_3000});

    // R5 drain while capturing
    cur = "R5";
    rdy = 1;
    for (int i = 0; i < 10; i++) step(i % 2, 1, 1, 32'h400 + i);
    rdy = 0;
    while (rd_valid) begin rdy = 1; @(negedge clk); rdy = 0; end

    // R7 wrap overwrites oldest
    cur = "R7";
    for (int i = 0; i < 20; i++) step(0, 0, 1, 32'(i));
    chk("R7 halt stays low", 48'(halt), 48'd0);
    for (int i = 4; i < 20; i++) pop_exp("R7", {16'd0, 32'(i)});

    // R8 breakpoint freeze
    cur = "R8";
    step(0, 0, 1, 32'h50);
    step(0, 0, 1, 32'h51, 1);
    step(0, 0, 1, 32'h52);
    pop_exp("R8", {16'd0, 32'h50});
    chk("R8 frozen", 48'(rd_valid), 48'd0);
    cfg(0, 0); cfg(1, 0);
    step(0, 0, 1, 32'h53);
    pop_exp("R8 re-enabled", {16'd0, 32'h53});

    // R10 mode locked while enabled
    cur = "R10";
    cfg(1, 1);
    for (int i = 0; i < 17; i++) step(0, 0, 1, 32'(i));
    chk("R10 mode kept wrap", 48'(halt), 48'd0);
    chk("R10 oldest overwritten", rd_data, {16'd0, 32'd1});
    while (rd_valid) begin rdy = 1; @(negedge clk); rdy = 0; end
    cfg(0, 1); cfg(1, 1);

    // R9 halt policy
    cur = "R9";
    for (int i = 0; i < 16; i++) step(0, 0, 1, 32'h100 + i);
    chk("R9 full no halt", 48'(halt), 48'd0);
    step(0, 0, 1, 32'h110);
    chk("R9 halt raised", 48'(halt), 48'd1);
    repeat (3) @(negedge clk);
    chk("R9 halt held", 48'(halt), 48'd1);
    pop_exp("R9", {16'd0, 32'h100});
    chk("R9 halt released", 48'(halt), 48'd0);
    for (int i = 1; i <= 16; i++) pop_exp("R9 no loss", {16'd0, 32'h100 + i});

    // R4 counter overflow
    cur = "R4";
    cfg(0, 0); cfg(1, 0);
    for (int i = 0; i < 32767; i++) step(1, 1, 0, 0);
    chk("R4 no early message", 48'(rd_valid), 48'd0);
    step(1, 1, 0, 0);
    step(0, 0, 1, 32'h77);
    pop_exp("R4 overflow", {16'd65534, 32'hFFFF_FFFF});
    pop_exp("R4 restart", {16'd2, 32'h77});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule